// File: doc/BRIEF.md
# Chipset Control Register File

This block is the software-visible register bank of a system chipset. It holds a global configuration word, the base and limit of a DMA address-translation table, a set of error-address words, an I/O cache byte-mask register, fifteen remote-speed words, four words for each of eight DMA channels, and a few miscellaneous control words. All of them are plain storage here. The engines that would act on them are outside the block.

A host reaches the bank over a simple synchronous request port. Each request carries an address, a write flag, an access size, write data, and a valid strobe. Byte, halfword and word accesses are supported. A narrow write is merged into the existing 32-bit contents, so the lanes it does not cover keep their values. Read data is registered and appears on the cycle after the request.

Two register classes behave differently from plain storage. The cache byte-mask word accumulates: each write ORs new bits into it, and a read that returns all ones empties it. The error-address words and a group of fixed status words are read-only. The cache tag and window words accept writes but always read as zero.

Top module: `chipset_regfile`

## Requirements
- R1: After a synchronous active-high reset, the bank holds these values:
  - configuration word (offset 0x000): 0x00000104, which is memory-size code 1 in bits 9:8 plus bit 2;
  - control word at 0x210: 0x00018186;
  - words at 0x220 and 0x238: 7;
  - every remote-speed word: 7;
  - every other word, and `rsp_rdata`: 0.
- R2: Only address bits 13:0 are decoded. Bits 1:0 do not take part in selecting a register, so any address with the same bits 13:2 reaches the same word.
- R3: A read request loads `rsp_rdata` at the clock edge that samples it. `rsp_rdata` keeps its value through cycles that carry no read.
- R4: A word write (size code 2 or 3) to the configuration word, the translation base (0x018), the translation limit (0x020) or the control word (0x210) replaces the word at the request edge. A read in the next cycle returns the new value.
- R5: Size code 1 is a halfword access, and address bit 1 selects the upper half. A read returns that half zero-extended. A write takes `req_wdata[15:0]` and keeps the other half.
- R6: Size code 0 is a byte access, and address bits 1:0 select lane 0 to 3. A read returns that lane zero-extended in bits 7:0. A write takes `req_wdata[7:0]` and keeps the other three lanes.
- R7: Fifteen read/write remote-speed words sit at 0x070 + 8·k for k = 0 to 14. The word addresses in between (0x074, 0x07C, …) are unmapped.
- R8: Thirty-two independent read/write DMA words sit at 0x100 + 8·k. Channel k/4 holds register k mod 4. The word addresses in between are unmapped.
- R9: A write to the byte-mask word (0x058) ORs the lane-placed write data into its contents. A bit that is already set is never cleared by a write.
- R10: A read of the byte-mask word returns its value. If that value was 0xFFFFFFFF, the word is 0 from the next cycle on. Otherwise it is unchanged.
- R11: Writes to the read-only words are ignored. Words 0x010, 0x038, 0x040 and 0x208 read 0. Words 0x220 and 0x238 read 7.
- R12: The write-only words 0x048, 0x050 and 0x060 accept writes and always read 0.
- R13: Any other offset reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled at the rising edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W (16) | Byte address; bits 13:0 are decoded |
| req_wdata | input | 32 | Write data, right-aligned for narrow writes |
| rsp_rdata | output | 32 | Registered read data, right-aligned for narrow reads |

## Verification
Every read result is due exactly one rising edge after the request. The bench drives each request at a falling edge, holds it across one rising edge, and compares `rsp_rdata` at the following falling edge. Writes take effect at the request edge. A write is therefore checked by a read issued in the very next request slot, and the bench model is updated at the same point. The byte-mask clear is checked in the same way: a second read, one request later, must return zero. Persistence of `rsp_rdata` is checked by comparing it after a write-only cycle with the value the preceding read left there.

// File: rtl/chipset_regs_pkg.sv
package chipset_regs_pkg;

  localparam logic [31:0] CFG_RST   = 32'h0000_0104;
  localparam logic [31:0] CTRL2_RST = 32'h0001_8186;
  localparam logic [31:0] SEVEN_RST = 32'h0000_0007;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_CFG,
    RK_XBASE,
    RK_XLIMIT,
    RK_ZERO_RO,
    RK_SEVEN_RO,
    RK_WONLY,
    RK_BMASK,
    RK_CTRL2,
    RK_SPEED,
    RK_DMA
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_sel_t;

  // Lanes touched by an access of the given size at the given byte offset.
  function automatic logic [31:0] lane_mask(logic [1:0] sz, logic [1:0] ln);
    case (sz)
      2'd0:    return 32'h0000_00FF << {ln, 3'b000};
      2'd1:    return ln[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Right-aligned write data moved into its lane position.
  function automatic logic [31:0] place_data(logic [31:0] d, logic [1:0] sz, logic [1:0] ln);
    case (sz)
      2'd0:    return {24'b0, d[7:0]} << {ln, 3'b000};
      2'd1:    return ln[1] ? {d[15:0], 16'b0} : {16'b0, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] merge_word(logic [31:0] old, logic [31:0] d,
                                             logic [1:0] sz, logic [1:0] ln);
    logic [31:0] m;
    m = lane_mask(sz, ln);
    return (old & ~m) | (place_data(d, sz, ln) & m);
  endfunction

  // Lane of a word, right-aligned and zero-extended.
  function automatic logic [31:0] pick_lane(logic [31:0] w, logic [1:0] sz, logic [1:0] ln);
    case (sz)
      2'd0:    return (w >> {ln, 3'b000}) & 32'h0000_00FF;
      2'd1:    return ln[1] ? {16'b0, w[31:16]} : {16'b0, w[15:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/chipset_reg_decode.sv
module chipset_reg_decode
  import chipset_regs_pkg::*;
#(
  parameter int DEC_W      = 14,
  parameter int N_SPEED    = 15,
  parameter int SPEED_BASE = 32'h070,
  parameter int N_CHAN     = 8,
  parameter int CHAN_REGS  = 4,
  parameter int DMA_BASE   = 32'h100
) (
  input  logic [DEC_W-3:0] word_idx,
  output reg_sel_t         sel
);
  localparam int STRIDE    = 8;
  localparam int SPEED_END = SPEED_BASE + STRIDE * N_SPEED;
  localparam int DMA_END   = DMA_BASE + STRIDE * N_CHAN * CHAN_REGS;

  logic [31:0] boff;
  assign boff = 32'(word_idx) << 2;

  always_comb begin
    sel.kind = RK_NONE;
    sel.idx  = '0;
    case (boff)
      32'h000: sel.kind = RK_CFG;
      32'h018: sel.kind = RK_XBASE;
      32'h020: sel.kind = RK_XLIMIT;
      32'h058: sel.kind = RK_BMASK;
      32'h210: sel.kind = RK_CTRL2;
      32'h010, 32'h038, 32'h040, 32'h208: sel.kind = RK_ZERO_RO;
      32'h220, 32'h238:                   sel.kind = RK_SEVEN_RO;
      32'h048, 32'h050, 32'h060:          sel.kind = RK_WONLY;
      default: begin
        if (!boff[2] && boff >= 32'(SPEED_BASE) && boff < 32'(SPEED_END)) begin
          sel.kind = RK_SPEED;
          sel.idx  = 8'((boff - 32'(SPEED_BASE)) >> 3);
        end else if (!boff[2] && boff >= 32'(DMA_BASE) && boff < 32'(DMA_END)) begin
          sel.kind = RK_DMA;
          sel.idx  = 8'((boff - 32'(DMA_BASE)) >> 3);
        end
      end
    endcase
  end

  always_comb begin
    if (sel.kind == RK_SPEED)
      AST_SPEED_IDX_RANGE: assert (32'(sel.idx) < 32'(N_SPEED)); // R7
    if (sel.kind == RK_DMA)
      AST_DMA_IDX_RANGE: assert (32'(sel.idx) < 32'(N_CHAN * CHAN_REGS)); // R8
  end

endmodule

// File: rtl/chipset_reg_lanes.sv
module chipset_reg_lanes
  import chipset_regs_pkg::*;
(
  input  logic [31:0] old_word,
  input  logic [31:0] wdata,
  input  logic [1:0]  size,
  input  logic [1:0]  lane,
  output logic [31:0] merged,
  output logic [31:0] rd_lane
);
  assign merged  = merge_word(old_word, wdata, size, lane);
  assign rd_lane = pick_lane(old_word, size, lane);

  always_comb begin
    if (size == 2'd0)
      AST_BYTE_KEEPS_LANES: assert (((merged ^ old_word) & ~(32'h0000_00FF << {lane, 3'b000})) == 32'h0); // R6
    if (size == 2'd1)
      AST_HALF_KEEPS_OTHER: assert ((lane[1] ? merged[15:0] : merged[31:16])
                                    == (lane[1] ? old_word[15:0] : old_word[31:16])); // R5
  end

endmodule

// File: rtl/chipset_regfile.sv
module chipset_regfile
  import chipset_regs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEC_W     = 14,
  parameter int N_SPEED   = 15,
  parameter int N_CHAN    = 8,
  parameter int CHAN_REGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata
);
  localparam int N_DMA = N_CHAN * CHAN_REGS;

  // Named events for the checks.
  logic     wr_fire, rd_fire, bmask_rd_clear;
  reg_sel_t sel;
  logic [31:0] cur_word, merged, rd_lane;
  logic [31:0] spd_word, dma_word;

  logic [31:0] cfg_q, xbase_q, xlim_q, bmask_q, ctrl2_q;
  logic [31:0] speed_q [N_SPEED];
  logic [31:0] dma_q   [N_DMA];

  logic unused_addr_hi;
  assign unused_addr_hi = ^req_addr[ADDR_W-1:DEC_W];

  assign wr_fire = req_valid &  req_write;
  assign rd_fire = req_valid & ~req_write;

  chipset_reg_decode #(
    .DEC_W     (DEC_W),
    .N_SPEED   (N_SPEED),
    .N_CHAN    (N_CHAN),
    .CHAN_REGS (CHAN_REGS)
  ) i_decode (
    .word_idx (req_addr[DEC_W-1:2]),
    .sel      (sel)
  );

  always_comb begin
    spd_word = '0;
    for (int i = 0; i < N_SPEED; i++)
      if (sel.idx == 8'(i)) spd_word |= speed_q[i];
    dma_word = '0;
    for (int i = 0; i < N_DMA; i++)
      if (sel.idx == 8'(i)) dma_word |= dma_q[i];
  end

  always_comb begin
    case (sel.kind)
      RK_CFG:      cur_word = cfg_q;
      RK_XBASE:    cur_word = xbase_q;
      RK_XLIMIT:   cur_word = xlim_q;
      RK_BMASK:    cur_word = bmask_q;
      RK_CTRL2:    cur_word = ctrl2_q;
      RK_SEVEN_RO: cur_word = SEVEN_RST;
      RK_SPEED:    cur_word = spd_word;
      RK_DMA:      cur_word = dma_word;
      default:     cur_word = '0;
    endcase
  end

  chipset_reg_lanes i_lanes (
    .old_word (cur_word),
    .wdata    (req_wdata),
    .size     (req_size),
    .lane     (req_addr[1:0]),
    .merged   (merged),
    .rd_lane  (rd_lane)
  );

  assign bmask_rd_clear = rd_fire && sel.kind == RK_BMASK && bmask_q == 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_RST;
      xbase_q <= '0;
      xlim_q  <= '0;
      ctrl2_q <= CTRL2_RST;
    end else if (wr_fire) begin
      if (sel.kind == RK_CFG)    cfg_q   <= merged;
      if (sel.kind == RK_XBASE)  xbase_q <= merged;
      if (sel.kind == RK_XLIMIT) xlim_q  <= merged;
      if (sel.kind == RK_CTRL2)  ctrl2_q <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bmask_q <= '0;
    else if (wr_fire && sel.kind == RK_BMASK)
      bmask_q <= bmask_q | merged;
    else if (bmask_rd_clear)
      bmask_q <= '0;
  end

  for (genvar g = 0; g < N_SPEED; g++) begin : g_speed
    always_ff @(posedge clk) begin
      if (rst)
        speed_q[g] <= SEVEN_RST;
      else if (wr_fire && sel.kind == RK_SPEED && sel.idx == 8'(g))
        speed_q[g] <= merged;
    end
  end

  for (genvar g = 0; g < N_DMA; g++) begin : g_dma
    always_ff @(posedge clk) begin
      if (rst)
        dma_q[g] <= '0;
      else if (wr_fire && sel.kind == RK_DMA && sel.idx == 8'(g))
        dma_q[g] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rsp_rdata <= '0;
    else if (rd_fire) rsp_rdata <= rd_lane;
  end

  AST_BMASK_ONLY_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && sel.kind == RK_BMASK) |=> ((bmask_q & $past(bmask_q)) == $past(bmask_q))); // R9
  AST_BMASK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bmask_rd_clear |=> (bmask_q == 32'h0)); // R10
  AST_BMASK_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && sel.kind == RK_BMASK && !bmask_rd_clear) |=> $stable(bmask_q)); // R10
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && sel.kind == RK_CFG) |=> $stable(cfg_q)); // R4
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rsp_rdata)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && sel.kind == RK_NONE) |=> (rsp_rdata == 32'h0)); // R13
  AST_RO_SEVEN: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && sel.kind == RK_SEVEN_RO && req_size[1]) |=> (rsp_rdata == 32'h7)); // R11

endmodule

// File: tb/test_chipset_regfile.sv
module test_chipset_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model of the readable state.
  logic [31:0] m_cfg, m_xb, m_xl, m_bmask, m_c2;
  logic [31:0] m_spd [15];
  logic [31:0] m_dma [32];

  always #10 clk = ~clk;   // 50 MHz

  chipset_regfile i_chipset_regfile (
    .clk, .rst, .req_valid, .req_write, .req_size, .req_addr, .req_wdata, .rsp_rdata
  );

  // 0 none, 1 cfg, 2 xbase, 3 xlimit, 4 bmask, 5 ctrl2, 6 ro7, 7 speed, 8 dma, 9 ro0, 10 wonly
  function automatic int cls(input logic [15:0] a);
    int b;
    b = int'(a[13:0]) & ~3;
    if (b == 0) return 1;
    if (b == 'h18) return 2;
    if (b == 'h20) return 3;
    if (b == 'h58) return 4;
    if (b == 'h210) return 5;
    if (b == 'h220 || b == 'h238) return 6;
    if (b == 'h10 || b == 'h38 || b == 'h40 || b == 'h208) return 9;
    if (b == 'h48 || b == 'h50 || b == 'h60) return 10;
    if (b >= 'h70 && b <= 'h70 + 8 * 14 && (b % 8) == 0) return 7;
    if (b >= 'h100 && b <= 'h1F8 && (b % 8) == 0) return 8;
    return 0;
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      0: return "R13";
      4: return "R9";
      6, 9: return "R11";
      7: return "R7";
      8: return "R8";
      10: return "R12";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [31:0] model_get(input logic [15:0] a);
    int b;
    b = int'(a[13:0]) & ~3;
    case (cls(a))
      1: return m_cfg;
      2: return m_xb;
      3: return m_xl;
      4: return m_bmask;
      5: return m_c2;
      6: return 32'd7;
      7: return m_spd[(b - 'h70) / 8];
      8: return m_dma[(b - 'h100) / 8];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] sub_mask(input logic [1:0] sz, input logic [1:0] ln);
    if (sz == 0) return 32'hFF * (32'd1 << (8 * ln));
    if (sz == 1) return ln[1] ? 32'hFFFF0000 : 32'h0000FFFF;
    return 32'hFFFFFFFF;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] ln);
    if (sz == 0) return (w / (32'd1 << (8 * ln))) % 256;
    if (sz == 1) return ln[1] ? w / 65536 : w % 65536;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = 32'h104; m_xb = 0; m_xl = 0; m_bmask = 0; m_c2 = 32'h18186;
    for (int i = 0; i < 15; i++) m_spd[i] = 7;
    for (int i = 0; i < 32; i++) m_dma[i] = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] m, nw, shifted;
    int b;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    m = sub_mask(sz, a[1:0]);
    if (sz == 0)      shifted = {24'b0, d[7:0]} * (32'd1 << (8 * a[1:0]));
    else if (sz == 1) shifted = a[1] ? {d[15:0], 16'b0} : {16'b0, d[15:0]};
    else              shifted = d;
    nw = (model_get(a) & ~m) | (shifted & m);
    b = int'(a[13:0]) & ~3;
    case (cls(a))
      1: m_cfg = nw;
      2: m_xb = nw;
      3: m_xl = nw;
      4: m_bmask = m_bmask | nw;
      5: m_c2 = nw;
      7: m_spd[(b - 'h70) / 8] = nw;
      8: m_dma[(b - 'h100) / 8] = nw;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, input string tag);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = sz; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    e = expect_rd(model_get(a), sz, a[1:0]);
    check(tag, rsp_rdata, e);
    if (cls(a) == 4 && m_bmask == 32'hFFFFFFFF) m_bmask = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rdata after reset", rsp_rdata, 32'h0);

    // R1: every word address after reset
    for (int w = 0; w < 4096; w++) begin
      logic [15:0] a;
      a = 16'(w * 4);
      rd(a, 2'd2, (cls(a) == 0) ? "R13" : "R1");
    end

    // Word writes over the mapped area and beyond, then read back
    for (int w = 0; w < 768; w++)
      wr(16'(w * 4), 2'd2, 32'h5A3C_0000 ^ (32'(w) * 32'h0101_0307));
    for (int w = 0; w < 768; w++) begin
      logic [15:0] a;
      a = 16'(w * 4);
      rd(a, 2'd2, tag_of(cls(a)));
    end

    // R4 immediate visibility on each RW scalar
    wr(16'h0000, 2'd3, 32'hCAFE_0001); rd(16'h0000, 2'd2, "R4 cfg");
    wr(16'h0018, 2'd2, 32'h1234_5678); rd(16'h0018, 2'd2, "R4 xbase");
    wr(16'h0210, 2'd2, 32'h0BAD_F00D); rd(16'h0210, 2'd2, "R4 ctrl2");

    // R2: high address bits and low two bits do not affect selection
    wr(16'hC018, 2'd2, 32'hA5A5_0F0F); rd(16'h0018, 2'd2, "R2 high alias");
    rd(16'h401B, 2'd2, "R2 low bits");
    wr(16'h8002, 2'd2, 32'h7777_1111); rd(16'h0000, 2'd2, "R2 cfg alias");

    // R5: halfword accesses
    for (int h = 0; h < 2; h++) begin
      logic [15:0] bases [4] = '{16'h0000, 16'h0210, 16'h00E0, 16'h01F8};
      for (int k = 0; k < 4; k++) begin
        wr(bases[k] + 16'(2 * h), 2'd1, 32'hFFFF_0000 | 32'(16'h9C00 + 16'(k * 16 + h)));
        rd(bases[k] + 16'(2 * h), 2'd1, "R5 half");
        rd(bases[k] + 16'(2 * (1 - h)), 2'd1, "R5 other half");
        rd(bases[k], 2'd2, "R5 word");
      end
    end

    // R6: byte lanes
    for (int ln = 0; ln < 4; ln++) begin
      wr(16'h0020 + 16'(ln), 2'd0, 32'hFFFF_FF00 | 32'(8'h30 + 8'(ln)));
      rd(16'h0020 + 16'(ln), 2'd0, "R6 byte");
      rd(16'h0020, 2'd2, "R6 word");
      wr(16'h0128 + 16'(ln), 2'd0, 32'(8'hE0 + 8'(ln)));
      rd(16'h0128, 2'd2, "R6 dma word");
    end

    // R7/R8: in-between word addresses unmapped
    wr(16'h0074, 2'd2, 32'hDEAD_BEEF); rd(16'h0074, 2'd2, "R7 gap");
    rd(16'h0070, 2'd2, "R7 neighbour");
    wr(16'h010C, 2'd2, 32'hDEAD_BEEF); rd(16'h010C, 2'd2, "R8 gap");
    rd(16'h0108, 2'd2, "R8 neighbour");

    // R9/R10: byte mask accumulate and clear
    wr(16'h0058, 2'd2, 32'hFFFF_FFFF); rd(16'h0058, 2'd2, "R10 full read");
    rd(16'h0058, 2'd2, "R10 cleared");
    wr(16'h0058, 2'd2, 32'h0F0F_0000); wr(16'h0058, 2'd2, 32'h0000_00F0);
    rd(16'h0058, 2'd2, "R9 or");
    wr(16'h0059, 2'd0, 32'h0000_00AA); rd(16'h0058, 2'd2, "R9 byte or");
    wr(16'h0058, 2'd2, 32'h0000_0000); rd(16'h0058, 2'd2, "R9 zero keeps");
    rd(16'h0058, 2'd2, "R10 partial keeps");
    wr(16'h005A, 2'd1, 32'h0000_FFFF); wr(16'h0058, 2'd2, 32'h0000_FFFF);
    rd(16'h005B, 2'd0, "R10 byte read of full");
    rd(16'h0058, 2'd2, "R10 cleared after byte read");

    // R11/R12: read-only and write-only words
    wr(16'h0220, 2'd2, 32'h1111_2222); rd(16'h0220, 2'd2, "R11 ro seven");
    wr(16'h0238, 2'd0, 32'h0000_00FF); rd(16'h0238, 2'd0, "R11 ro seven byte");
    wr(16'h0208, 2'd2, 32'h3333_4444); rd(16'h0208, 2'd2, "R11 ro zero");
    wr(16'h0050, 2'd2, 32'h5555_6666); rd(16'h0050, 2'd2, "R12 write-only");

    // R3: rdata holds across non-read cycles
    rd(16'h0018, 2'd2, "R3 load");
    last = rsp_rdata;
    wr(16'h0300, 2'd2, 32'h0);
    check("R3 hold after write", rsp_rdata, last);
    @(negedge clk);
    check("R3 hold idle", rsp_rdata, last);

    // R13 write to unmapped leaves neighbours
    wr(16'h0004, 2'd2, 32'hFFFF_FFFF); rd(16'h0000, 2'd2, "R13 neighbour");
    rd(16'h0004, 2'd2, "R13 unmapped");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule